// File: doc/BRIEF.md
# Dual-Edge Video Stream Splitter

The block takes one 8-bit video bus that changes twice per cycle of a 27 MHz line-locked clock. It samples the bus on the rising edge and on the falling edge. The two sample streams are independent Cb-Y-Cr 4:2:2 word sequences of the kind used on parallel digital video links, with 720 active pixels per line in each. One stream goes to a composite encoding lane and the other to a component/RGB lane. A static select input decides which clock edge feeds which lane.

The falling-edge sample is held and moved across on the next rising edge, so both lanes run in the rising-edge domain. Each lane watches its own words for the four-word timing reference (all-ones, all-zeros, all-zeros, status word). It uses that reference to set the phase of its component tag, and it raises a valid strobe only for picture and ancillary words that follow a complete reference.

Top module: `vsplit_dual_edge`

## Requirements
- R1: With `swap_sel` low, the byte present on `din` at rising edge k appears on `enc_data` after rising edge k+1, and the byte present at the falling edge just after edge k appears on `rgb_data` after rising edge k+2.
- R2: With `swap_sel` high, the lanes are exchanged: rising-edge bytes reach `rgb_data` and falling-edge bytes reach `enc_data`, with the same latencies as in R1.
- R3: Every output changes only on rising edges of `clk`. Values seen just after a falling edge equal the values seen just after the preceding rising edge.
- R4: The four words of a timing reference (8'hFF, 8'h00, 8'h00, then any status word) are all output with valid low. A word equal to 8'hFF is never output with valid high.
- R5: The word that follows a status word carries tag 0 (Cb). Later words carry tags 1 (Y0), 2 (Cr), 3 (Y1), 0, … in turn. Each word that is output with valid high advances the tag by one.
- R6: After reset, a lane keeps valid low until it has received one complete timing reference.
- R7: An 8'hFF that is not followed by two 8'h00 words is an aborted reference. The 8'hFF and any 8'h00 taken as part of it are output with valid low and do not advance the tag. The first word that breaks the pattern is handled as an ordinary word and takes the tag that the word after the last valid one would have had.
- R8: While `rst_n` is low, both lanes output valid low, data 8'h00 and tag 0, and lock and tag phase are cleared.
- R9: Each lane tracks its own references and tag phase. A reference or aborted reference in one lane changes neither the valid nor the tag sequence of the other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz line-locked clock; bus sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_sel | input | 1 | 0: rising edge feeds encode lane; 1: falling edge feeds encode lane |
| din | input | 8 | Double-rate multiplexed video byte bus |
| enc_data | output | 8 | Encode lane word |
| enc_tag | output | 2 | Encode lane component tag (0 Cb, 1 Y0, 2 Cr, 3 Y1) |
| enc_valid | output | 1 | Encode lane word is a valid video word |
| rgb_data | output | 8 | Component lane word |
| rgb_tag | output | 2 | Component lane component tag (0 Cb, 1 Y0, 2 Cr, 3 Y1) |
| rgb_valid | output | 1 | Component lane word is a valid video word |

## Verification
The assertions assume that `swap_sel` is static and is changed only while `rst_n` is low. They also assume that 8'hFF and 8'h00 appear on the bus only inside timing references or as a deliberately broken reference. The stimulus holds `swap_sel` fixed for each pass and changes it only during reset. It drives each byte one nanosecond after the opposite clock edge, so every sample is taken well inside a stable window. The two streams carry their references at different cycles, and each contains one aborted reference, so that the lanes are seen to be independent.

// File: rtl/vsplit_pkg.sv
package vsplit_pkg;

  typedef enum logic [1:0] {
    TAG_CB = 2'd0,
    TAG_Y0 = 2'd1,
    TAG_CR = 2'd2,
    TAG_Y1 = 2'd3
  } comp_tag_e;

  typedef enum logic [1:0] {
    HDR_IDLE  = 2'd0,
    HDR_ONES  = 2'd1,
    HDR_ZERO1 = 2'd2,
    HDR_ZERO2 = 2'd3
  } hdr_state_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_ENC  = 0;
  localparam int unsigned LANE_RGB  = 1;

  function automatic comp_tag_e tag_advance(input comp_tag_e t);
    return comp_tag_e'(t + 2'd1);
  endfunction

endpackage

// File: rtl/vsplit_edge_capture.sv
module vsplit_edge_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] fall_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_o <= '0;
    else        rise_o <= bus_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_hold <= '0;
    else        fall_hold <= bus_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fall_o <= '0;
    else        fall_o <= fall_hold;
  end

endmodule

// File: rtl/vsplit_lane.sv
module vsplit_lane
  import vsplit_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o,
  output logic [1:0]   tag_o,
  output logic         valid_o,
  output logic         sync_o
);

  function automatic logic is_ones(input logic [W-1:0] w);
    return w == {W{1'b1}};
  endfunction

  function automatic logic is_zero(input logic [W-1:0] w);
    return w == {W{1'b0}};
  endfunction

  hdr_state_e hs_q, hs_d;
  comp_tag_e  ph_q, ph_d;
  logic       lock_q, lock_d;
  logic       word_valid, word_sync;
  comp_tag_e  word_tag;
  logic       plain_word;

  always_comb begin
    hs_d       = hs_q;
    ph_d       = ph_q;
    lock_d     = lock_q;
    word_valid = 1'b0;
    word_sync  = 1'b0;
    word_tag   = ph_q;
    plain_word = 1'b0;
    case (hs_q)
      HDR_ZERO2: begin
        hs_d      = HDR_IDLE;
        ph_d      = TAG_CB;
        lock_d    = 1'b1;
        word_sync = 1'b1;
      end
      HDR_ONES: begin
        if (is_zero(word_i)) hs_d = HDR_ZERO1;
        else                 plain_word = 1'b1;
      end
      HDR_ZERO1: begin
        if (is_zero(word_i)) hs_d = HDR_ZERO2;
        else                 plain_word = 1'b1;
      end
      default: plain_word = 1'b1;
    endcase
    if (plain_word) begin
      if (is_ones(word_i)) begin
        hs_d = HDR_ONES;
      end else begin
        hs_d       = HDR_IDLE;
        word_valid = lock_q;
        ph_d       = tag_advance(ph_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= HDR_IDLE;
      ph_q    <= TAG_CB;
      lock_q  <= 1'b0;
      data_o  <= '0;
      tag_o   <= TAG_CB;
      valid_o <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      hs_q    <= hs_d;
      ph_q    <= ph_d;
      lock_q  <= lock_d;
      data_o  <= word_i;
      tag_o   <= word_tag;
      valid_o <= word_valid;
      sync_o  <= word_sync;
    end
  end

endmodule

// File: rtl/vsplit_dual_edge.sv
module vsplit_dual_edge
  import vsplit_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         swap_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] enc_data,
  output logic [1:0]   enc_tag,
  output logic         enc_valid,
  output logic [W-1:0] rgb_data,
  output logic [1:0]   rgb_tag,
  output logic         rgb_valid
);

  logic [W-1:0] rise_word;
  logic [W-1:0] fall_word;
  logic [W-1:0] lane_in    [NUM_LANES];
  logic [W-1:0] lane_data  [NUM_LANES];
  logic [1:0]   lane_tag   [NUM_LANES];
  logic         lane_valid [NUM_LANES];
  logic         lane_sync  [NUM_LANES];

  vsplit_edge_capture #(.W(W)) i_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_i  (din),
    .rise_o (rise_word),
    .fall_o (fall_word)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic RISE_DEFAULT = (g == LANE_ENC);
    assign lane_in[g] = (RISE_DEFAULT ^ swap_sel) ? rise_word : fall_word;

    vsplit_lane #(.W(W)) i_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_i  (lane_in[g]),
      .data_o  (lane_data[g]),
      .tag_o   (lane_tag[g]),
      .valid_o (lane_valid[g]),
      .sync_o  (lane_sync[g])
    );
  end

  logic [W-1:0] enc_word_in, rgb_word_in;
  logic         enc_sync, rgb_sync;
  assign enc_word_in = lane_in[LANE_ENC];
  assign rgb_word_in = lane_in[LANE_RGB];
  assign enc_sync    = lane_sync[LANE_ENC];
  assign rgb_sync    = lane_sync[LANE_RGB];

  assign enc_data  = lane_data[LANE_ENC];
  assign enc_tag   = lane_tag[LANE_ENC];
  assign enc_valid = lane_valid[LANE_ENC];
  assign rgb_data  = lane_data[LANE_RGB];
  assign rgb_tag   = lane_tag[LANE_RGB];
  assign rgb_valid = lane_valid[LANE_RGB];

endmodule

// File: rtl/vsplit_dual_edge_chk.sv
module vsplit_dual_edge_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         swap_sel,
  input logic [W-1:0] rise_word,
  input logic [W-1:0] fall_word,
  input logic [W-1:0] enc_word_in,
  input logic [W-1:0] rgb_word_in,
  input logic         enc_sync,
  input logic         rgb_sync,
  input logic [W-1:0] enc_data,
  input logic [1:0]   enc_tag,
  input logic         enc_valid,
  input logic [W-1:0] rgb_data,
  input logic [1:0]   rgb_tag,
  input logic         rgb_valid
);

  logic enc_seen, rgb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_seen <= 1'b0;
      rgb_seen <= 1'b0;
    end else begin
      if (enc_sync) enc_seen <= 1'b1;
      if (rgb_sync) rgb_seen <= 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r8: assert (!enc_valid && !rgb_valid);
    end
  end

  p_rise_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(swap_sel) |-> (enc_data == $past(rise_word) && rgb_data == $past(fall_word)));

  p_swap_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(swap_sel) |-> (enc_data == $past(fall_word) && rgb_data == $past(rise_word)));

  p_enc_ones_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enc_word_in) == {W{1'b1}}) |-> !enc_valid);

  p_rgb_ones_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rgb_word_in) == {W{1'b1}}) |-> !rgb_valid);

  p_enc_tag_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_valid && $past(enc_valid)) |-> (enc_tag == $past(enc_tag) + 2'd1));

  p_rgb_tag_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && $past(rgb_valid)) |-> (rgb_tag == $past(rgb_tag) + 2'd1));

  p_enc_cb_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enc_sync |=> (!enc_valid || enc_tag == 2'd0));

  p_rgb_cb_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_sync |=> (!rgb_valid || rgb_tag == 2'd0));

  p_enc_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> enc_seen);

  p_rgb_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid |-> rgb_seen);

endmodule

bind vsplit_dual_edge vsplit_dual_edge_chk #(.W(W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .swap_sel    (swap_sel),
  .rise_word   (rise_word),
  .fall_word   (fall_word),
  .enc_word_in (enc_word_in),
  .rgb_word_in (rgb_word_in),
  .enc_sync    (enc_sync),
  .rgb_sync    (rgb_sync),
  .enc_data    (enc_data),
  .enc_tag     (enc_tag),
  .enc_valid   (enc_valid),
  .rgb_data    (rgb_data),
  .rgb_tag     (rgb_tag),
  .rgb_valid   (rgb_valid)
);

// File: tb/test_vsplit_dual_edge.sv
module test_vsplit_dual_edge;

  localparam int N = 36;
  // each entry: {byte at rising edge, byte at following falling edge}
  localparam logic [15:0] STIM [N] = '{
    16'h1121, 16'h12FF, 16'hFF00, 16'h0000, 16'h00C7, 16'h8030,
    16'h4031, 16'h4132, 16'h4233, 16'h4334, 16'h4435, 16'h4536,
    16'hFF37, 16'h00FF, 16'hAB00, 16'h4600, 16'h47DA, 16'hFF38,
    16'h0039, 16'h003A, 16'h9DFF, 16'h505C, 16'h513B, 16'h523C,
    16'h533D, 16'h543E, 16'hFFFF, 16'h0000, 16'h0000, 16'hB6F1,
    16'h6070, 16'h6171, 16'h6272, 16'h6373, 16'h6474, 16'h6575
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swap_sel = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] enc_data, rgb_data;
  logic [1:0] enc_tag, rgb_tag;
  logic       enc_valid, rgb_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state per lane (0 = encode, 1 = component)
  logic       m_lk [2];
  int         m_tp [2];
  logic [1:0] m_ph [2];
  logic [7:0] pend [2];
  logic [7:0] prev_f;

  always #5 clk = ~clk;

  vsplit_dual_edge i_vsplit_dual_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_sel  (swap_sel),
    .din       (din),
    .enc_data  (enc_data),
    .enc_tag   (enc_tag),
    .enc_valid (enc_valid),
    .rgb_data  (rgb_data),
    .rgb_tag   (rgb_tag),
    .rgb_valid (rgb_valid)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_lk[i] = 1'b0; m_tp[i] = 0; m_ph[i] = 2'd0; pend[i] = 8'h00;
    end
    prev_f = 8'h00;
  endtask

  // independent restatement of the lane rules
  task automatic model_word(input int ch, input logic [7:0] w,
                            output logic v, output logic [1:0] t);
    bit ordinary;
    v = 1'b0;
    t = m_ph[ch];
    ordinary = 1'b1;
    if (m_tp[ch] == 3) begin
      m_tp[ch] = 0; m_ph[ch] = 2'd0; m_lk[ch] = 1'b1; ordinary = 1'b0;
    end else if (m_tp[ch] != 0 && w == 8'h00) begin
      m_tp[ch] = m_tp[ch] + 1; ordinary = 1'b0;
    end
    if (ordinary) begin
      if (w == 8'hFF) m_tp[ch] = 1;
      else begin
        m_tp[ch] = 0; v = m_lk[ch]; t = m_ph[ch]; m_ph[ch] = m_ph[ch] + 2'd1;
      end
    end
  endtask

  task automatic compare_lanes(input logic sw);
    logic v0, v1;
    logic [1:0] t0, t1;
    model_word(0, pend[0], v0, t0);
    model_word(1, pend[1], v1, t1);
    check(sw ? "R2" : "R1", "enc data", enc_data, pend[0]);
    check(sw ? "R2" : "R1", "rgb data", rgb_data, pend[1]);
    check("R4/R6/R7", "enc valid", enc_valid, v0);
    check("R4/R6/R7", "rgb valid", rgb_valid, v1);
    if (v0) check("R5/R9", "enc tag", enc_tag, t0);
    if (v1) check("R5/R9", "rgb tag", rgb_tag, t1);
  endtask

  task automatic do_reset(input logic sw);
    @(negedge clk); #1;
    rst_n = 1'b0; swap_sel = sw; din = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state at the ports
    check("R8", "enc valid in reset", enc_valid, 0);
    check("R8", "rgb valid in reset", rgb_valid, 0);
    check("R8", "enc data in reset", enc_data, 0);
    check("R8", "rgb data in reset", rgb_data, 0);
    check("R8", "enc tag in reset", enc_tag, 0);
    check("R8", "rgb tag in reset", rgb_tag, 0);
    model_clear();
    rst_n = 1'b1;
  endtask

  task automatic run_table(input logic sw);
    logic [7:0] s_ed, s_rd;
    logic [1:0] s_et, s_rt;
    logic       s_ev, s_rv;
    for (int k = 0; k < N; k++) begin
      din = STIM[k][15:8];
      @(posedge clk); #1;
      compare_lanes(sw);
      pend[0] = sw ? prev_f : STIM[k][15:8];
      pend[1] = sw ? STIM[k][15:8] : prev_f;
      s_ed = enc_data; s_rd = rgb_data; s_et = enc_tag; s_rt = rgb_tag;
      s_ev = enc_valid; s_rv = rgb_valid;
      din = STIM[k][7:0];
      @(negedge clk); #1;
      // R3: nothing moves on the falling edge
      check("R3", "outputs stable over falling edge",
            {enc_data, rgb_data, enc_tag, rgb_tag, enc_valid, rgb_valid},
            {s_ed, s_rd, s_et, s_rt, s_ev, s_rv});
      prev_f = STIM[k][7:0];
    end
  endtask

  initial begin
    model_clear();
    do_reset(1'b0);
    run_table(1'b0);
    do_reset(1'b1);
    run_table(1'b1);
    do_reset(1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule